// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block supervises software by counting down from a programmable reload value and raising a fault request toward the reset controller if the count runs out. The count advances once every 128 pulses of a slow-clock tick. Each tick arrives as a one-cycle enable in the system clock domain. Software must restart the count with a keyed command before it expires. With the default 12-bit count of 0xFFF and a 32.768 kHz tick, the timeout is about 16 seconds.

Software can also program a restart window. A restart that comes too early, while the count is still above the window value, is treated as an error. This catches code stuck in a loop that keeps restarting the timer. The mode register takes only its first write after reset, so runaway code cannot reconfigure or disable the watchdog afterwards.

Two sticky flags record an underflow and a window error. They can raise an interrupt, and a read of the status register clears them. The block has simple write and read ports and four register addresses: mode, control, status and counter value.

Top module: `wdog_window`

## Requirements
- R1: After reset, the mode register reads 0x0FFF2FFF: reload 0xFFF in bits 11:0, fault enable set in bit 13, and window 0xFFF in bits 27:16. The counter (address 3) reads 0xFFF, the status (address 2) reads 0, and fault and irq are low.
- R2: While counting is enabled, the counter decrements by one on every 128th slow tick counted since the last reload.
- R3: The mode register (address 0) accepts only its first write after reset. Every later write leaves its readback unchanged.
- R4: The accepted mode write loads the counter with the new reload value and clears the tick prescaler.
- R5: A control write (address 1) with bits 31:24 not equal to 0xA5, or with bit 0 clear, has no effect on the counter.
- R6: A keyed restart (0xA5 in bits 31:24, bit 0 set) loads the counter from the reload value and clears the prescaler.
- R7: A keyed restart taken while the counter is above the window value and at or below the reload value sets the error flag (status bit 1) and asserts fault. This happens even when counting is disabled, and the counter is still reloaded. A restart at or below the window value raises no error.
- R8: When the window value is greater than or equal to the reload value, no restart raises an error.
- R9: A tick step that arrives while the counter is at zero sets the underflow flag (status bit 0). The counter then stays at zero. fault is asserted only if fault enable (mode bit 13) is set.
- R10: irq is high exactly when interrupt enable (mode bit 12) is set and either status flag is set.
- R11: A status read clears both flags, irq and fault. An error or underflow event in the same cycle as the read wins, and its flag and fault stay set.
- R12: Disable (mode bit 15) stops counting. Debug halt (bit 28) freezes counting while the debug input is high, and idle halt (bit 29) freezes counting while the idle input is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | One-cycle slow-clock enable pulse |
| cpu_idle | input | 1 | Processor idle indicator |
| cpu_debug | input | 1 | Processor debug-state indicator |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 mode, 1 control |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe (a status read clears the flags) |
| rd_addr | input | 2 | Read address: 0 mode, 2 status, 3 counter |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| fault | output | 1 | Fault request to the reset controller |
| irq | output | 1 | Interrupt request |

## Verification
The bench counts ticks exactly across a decrement boundary. A prescaler that is off by one, or one that is not cleared by a restart, shifts that step by a cycle. It restarts on both sides of the window edge, with counting disabled, and with the window at or above the reload value. A wrong compare would either flag legal restarts or miss early ones. It drives the counter past zero to catch a wrap back to 0xFFF, and checks that fault follows the enable bit. It issues a second mode write, bad keys, and a status read in the same cycle as a new error, where a design giving the read priority would lose the fault.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned CNT_W  = 12;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_MODE = 2'd0,
    REG_CTRL = 2'd1,
    REG_STAT = 2'd2,
    REG_CNT  = 2'd3
  } reg_addr_e;

  // mode register field positions
  localparam int unsigned RELOAD_LSB = 0;
  localparam int unsigned IEN_BIT    = 12;
  localparam int unsigned RSTEN_BIT  = 13;
  localparam int unsigned DIS_BIT    = 15;
  localparam int unsigned WIN_LSB    = 16;
  localparam int unsigned DHALT_BIT  = 28;
  localparam int unsigned IHALT_BIT  = 29;

  // control register fields
  localparam int unsigned KEY_LSB    = 24;
  localparam int unsigned KEY_W      = 8;
  localparam int unsigned RESTART_BIT = 0;

  typedef struct packed {
    logic             halt_idle;
    logic             halt_dbg;
    logic [CNT_W-1:0] win;
    logic             dis;
    logic             rsten;
    logic             ien;
    logic [CNT_W-1:0] reload;
  } mode_t;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int unsigned PRE_W = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  input  logic tick,
  output logic step
);
  logic [PRE_W-1:0] pre_q, pre_d;

  assign step = run && tick && (pre_q == {PRE_W{1'b1}}) && !clr;

  always_comb begin
    pre_d = pre_q;
    if (clr)
      pre_d = '0;
    else if (run && tick)
      pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  output logic [W-1:0] cnt,
  output logic         unf_evt
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         exp_q, exp_d;

  assign cnt = cnt_q;

  always_comb begin
    cnt_d   = cnt_q;
    exp_d   = exp_q;
    unf_evt = 1'b0;
    if (load) begin
      cnt_d = load_val;
      exp_d = 1'b0;
    end else if (step) begin
      if (cnt_q != '0) begin
        cnt_d = cnt_q - 1'b1;
      end else if (!exp_q) begin
        exp_d   = 1'b1;
        unf_evt = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= {W{1'b1}};
      exp_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      exp_q <= exp_d;
    end
  end
endmodule

// File: rtl/wdog_status.sv
module wdog_status (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic err_evt,
  input  logic unf_evt,
  input  logic rsten,
  input  logic ien,
  output logic stat_err,
  output logic stat_unf,
  output logic fault,
  output logic irq
);
  logic err_q, err_d, unf_q, unf_d, flt_q, flt_d;

  always_comb begin
    err_d = clr ? 1'b0 : err_q;
    unf_d = clr ? 1'b0 : unf_q;
    flt_d = clr ? 1'b0 : flt_q;
    if (err_evt) begin
      err_d = 1'b1;
      flt_d = 1'b1;
    end
    if (unf_evt) begin
      unf_d = 1'b1;
      if (rsten) flt_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
      unf_q <= 1'b0;
      flt_q <= 1'b0;
    end else begin
      err_q <= err_d;
      unf_q <= unf_d;
      flt_q <= flt_d;
    end
  end

  assign stat_err = err_q;
  assign stat_unf = unf_q;
  assign fault    = flt_q;
  assign irq      = ien && (err_q || unf_q);
endmodule

// File: rtl/wdog_window.sv
module wdog_window
  import wdog_pkg::*;
#(
  parameter int unsigned PRE_W = 7,
  parameter logic [KEY_W-1:0] KEY = 8'hA5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_tick,
  input  logic              cpu_idle,
  input  logic              cpu_debug,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              fault,
  output logic              irq
);
  mode_t            mode_q, mode_d, mode_wval;
  logic             lock_q, lock_d;
  logic             mode_try, mode_wr, restart, load, run, step;
  logic             err_evt, unf_evt, stat_clr, stat_err, stat_unf;
  logic [CNT_W-1:0] cnt, load_val;
  logic [DATA_W-1:0] mode_rd;
  logic             unused_bits;

  assign unused_bits = wr_data[14];

  // decode of the write port
  assign mode_wval.reload    = wr_data[RELOAD_LSB +: CNT_W];
  assign mode_wval.ien       = wr_data[IEN_BIT];
  assign mode_wval.rsten     = wr_data[RSTEN_BIT];
  assign mode_wval.dis       = wr_data[DIS_BIT];
  assign mode_wval.win       = wr_data[WIN_LSB +: CNT_W];
  assign mode_wval.halt_dbg  = wr_data[DHALT_BIT];
  assign mode_wval.halt_idle = wr_data[IHALT_BIT];

  assign mode_try = wr_en && (wr_addr == REG_MODE);
  assign mode_wr  = mode_try && !lock_q;
  assign restart  = wr_en && (wr_addr == REG_CTRL)
                 && (wr_data[KEY_LSB +: KEY_W] == KEY) && wr_data[RESTART_BIT];
  assign load     = mode_wr || restart;
  assign load_val = mode_wr ? mode_wval.reload : mode_q.reload;

  // window check: early restart is an error regardless of disable
  assign err_evt  = restart && (cnt > mode_q.win) && (cnt <= mode_q.reload);

  assign run = !mode_q.dis
            && !(mode_q.halt_idle && cpu_idle)
            && !(mode_q.halt_dbg  && cpu_debug);

  assign stat_clr = rd_en && (rd_addr == REG_STAT);

  always_comb begin
    mode_d = mode_q;
    lock_d = lock_q;
    if (mode_wr) begin
      mode_d = mode_wval;
      lock_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q.reload    <= {CNT_W{1'b1}};
      mode_q.ien       <= 1'b0;
      mode_q.rsten     <= 1'b1;
      mode_q.dis       <= 1'b0;
      mode_q.win       <= {CNT_W{1'b1}};
      mode_q.halt_dbg  <= 1'b0;
      mode_q.halt_idle <= 1'b0;
      lock_q           <= 1'b0;
    end else begin
      mode_q <= mode_d;
      lock_q <= lock_d;
    end
  end

  wdog_prescaler #(.PRE_W(PRE_W)) i_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (load),
    .run   (run),
    .tick  (slow_tick),
    .step  (step)
  );

  wdog_counter #(.W(CNT_W)) i_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (load_val),
    .step     (step),
    .cnt      (cnt),
    .unf_evt  (unf_evt)
  );

  wdog_status i_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (stat_clr),
    .err_evt  (err_evt),
    .unf_evt  (unf_evt),
    .rsten    (mode_q.rsten),
    .ien      (mode_q.ien),
    .stat_err (stat_err),
    .stat_unf (stat_unf),
    .fault    (fault),
    .irq      (irq)
  );

  always_comb begin
    mode_rd = '0;
    mode_rd[RELOAD_LSB +: CNT_W] = mode_q.reload;
    mode_rd[IEN_BIT]             = mode_q.ien;
    mode_rd[RSTEN_BIT]           = mode_q.rsten;
    mode_rd[DIS_BIT]             = mode_q.dis;
    mode_rd[WIN_LSB +: CNT_W]    = mode_q.win;
    mode_rd[DHALT_BIT]           = mode_q.halt_dbg;
    mode_rd[IHALT_BIT]           = mode_q.halt_idle;
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      REG_MODE: rd_data = mode_rd;
      REG_STAT: rd_data = {{(DATA_W-2){1'b0}}, stat_err, stat_unf};
      REG_CNT:  rd_data = {{(DATA_W-CNT_W){1'b0}}, cnt};
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/wdog_window_chk.sv
module wdog_window_chk #(
  parameter int unsigned W = 12
) (
  input logic         clk,
  input logic         rst_n,
  input logic         load,
  input logic [W-1:0] cnt,
  input logic         err_evt,
  input logic         unf_evt,
  input logic         rsten,
  input logic         dis,
  input logic         clr,
  input logic         fault,
  input logic         stat_err,
  input logic         stat_unf,
  input logic         lock,
  input logic         mode_try,
  input logic [31:0]  mode_rd
);
  a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (cnt == $past(cnt) || cnt == $past(cnt) - 1'b1));

  a_r3_mode_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && mode_try) |=> $stable(mode_rd));

  a_r7_err_faults: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |=> (fault && stat_err));

  a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && !load) |=> (cnt == '0));

  a_r9_unf_faults: assert property (@(posedge clk) disable iff (!rst_n)
    (unf_evt && rsten) |=> (fault && stat_unf));

  a_r11_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !err_evt && !unf_evt) |=> (!fault && !stat_err && !stat_unf));

  a_r12_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dis && !load) |=> $stable(cnt));
endmodule

bind wdog_window wdog_window_chk #(.W(wdog_pkg::CNT_W)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .load     (load),
  .cnt      (cnt),
  .err_evt  (err_evt),
  .unf_evt  (unf_evt),
  .rsten    (mode_q.rsten),
  .dis      (mode_q.dis),
  .clr      (stat_clr),
  .fault    (fault),
  .stat_err (stat_err),
  .stat_unf (stat_unf),
  .lock     (lock_q),
  .mode_try (mode_try),
  .mode_rd  (mode_rd)
);

// File: tb/test_wdog_window.sv
module test_wdog_window;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        slow_tick, cpu_idle, cpu_debug;
  logic        wr_en, rd_en;
  logic [1:0]  wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;
  logic        fault, irq;

  int n_checks = 0;
  int n_errors = 0;
  int cycles = 0;

  localparam logic [31:0] RESTART = 32'hA500_0001;

  wdog_window i_wdog_window (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .cpu_idle(cpu_idle),
    .cpu_debug(cpu_debug), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .fault(fault), .irq(irq)
  );

  always #10 clk = ~clk;

  function automatic logic [31:0] mode_word(input logic [11:0] rel, input logic [11:0] win,
                                            input logic ien, input logic rsten, input logic dis,
                                            input logic dh, input logic ih);
    return {2'b00, ih, dh, win, dis, 1'b0, rsten, ien, rel};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; slow_tick = 0; cpu_idle = 0; cpu_debug = 0;
    wr_en = 0; rd_en = 0; wr_addr = 0; rd_addr = 0; wr_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1; rd_addr = a;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic tick(input int n);
    @(negedge clk);
    slow_tick = 1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    slow_tick = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    rd(0, d); chk("R1 mode reset", d, 32'h0FFF_2FFF);
    rd(3, d); chk("R1 counter reset", d, 32'hFFF);
    rd(2, d); chk("R1 status reset", d, 0);
    chk("R1 fault/irq reset", {fault, irq}, 0);
  endtask

  task automatic t_prescale_key();
    logic [31:0] d;
    do_reset();
    tick(127); rd(3, d); chk("R2 before 128th tick", d, 32'hFFF);
    tick(1);   rd(3, d); chk("R2 at 128th tick", d, 32'hFFE);
    wr(1, 32'h5A00_0001); rd(3, d); chk("R5 wrong key", d, 32'hFFE);
    wr(1, 32'hA500_0000); rd(3, d); chk("R5 restart bit clear", d, 32'hFFE);
    tick(100);
    wr(1, RESTART); rd(3, d); chk("R6 restart reloads", d, 32'hFFF);
    tick(127); rd(3, d); chk("R6 prescaler cleared", d, 32'hFFF);
    tick(1);   rd(3, d); chk("R6 step after 128", d, 32'hFFE);
    rd(2, d); chk("R8 default window no error", d, 0);
  endtask

  task automatic t_mode_once();
    logic [31:0] d;
    do_reset();
    tick(60);
    wr(0, mode_word(12'h010, 12'h010, 0, 1, 0, 0, 0));
    rd(3, d); chk("R4 mode write loads counter", d, 32'h010);
    tick(127); rd(3, d); chk("R4 prescaler cleared", d, 32'h010);
    tick(1);   rd(3, d); chk("R4 step after 128", d, 32'h00F);
    wr(0, mode_word(12'h123, 12'h456, 1, 0, 1, 1, 1));
    rd(0, d); chk("R3 second write ignored", d, mode_word(12'h010, 12'h010, 0, 1, 0, 0, 0));
    rd(3, d); chk("R3 counter untouched", d, 32'h00F);
  endtask

  task automatic t_window();
    logic [31:0] d;
    do_reset();
    wr(0, mode_word(12'h100, 12'h080, 1, 1, 0, 0, 0));
    wr(1, RESTART);
    chk("R7 early restart fault", fault, 1);
    chk("R10 irq on error", irq, 1);
    rd(3, d); chk("R7 counter reloaded", d, 32'h100);
    rd(2, d); chk("R7 error flag", d, 2);
    chk("R11 read clears fault/irq", {fault, irq}, 0);
    tick(128 * 128);
    rd(3, d); chk("R2 counted into window", d, 32'h080);
    wr(1, RESTART);
    rd(2, d); chk("R7 restart at window edge legal", d, 0);
    chk("R7 no fault in window", fault, 0);
  endtask

  task automatic t_window_disabled();
    logic [31:0] d;
    do_reset();
    wr(0, mode_word(12'h100, 12'h000, 0, 0, 1, 0, 0));
    tick(300);
    rd(3, d); chk("R12 disabled holds", d, 32'h100);
    wr(1, RESTART);
    chk("R7 error while disabled", fault, 1);
    rd(2, d); chk("R7 error flag while disabled", d, 2);
  endtask

  task automatic t_wide_window();
    logic [31:0] d;
    do_reset();
    wr(0, mode_word(12'h100, 12'h200, 1, 1, 0, 0, 0));
    wr(1, RESTART);
    rd(2, d); chk("R8 window above reload no error", d, 0);
    chk("R8 no fault", {fault, irq}, 0);
  endtask

  task automatic t_underflow();
    logic [31:0] d;
    do_reset();
    wr(0, mode_word(12'h002, 12'h002, 0, 1, 0, 0, 0));
    tick(383); rd(3, d); chk("R9 reaches zero", d, 0);
    chk("R9 no fault at zero", fault, 0);
    tick(1);
    chk("R9 fault on underflow", fault, 1);
    chk("R10 irq off without enable", irq, 0);
    tick(256); rd(3, d); chk("R9 no wrap", d, 0);
    rd(2, d); chk("R9 underflow flag", d, 1);
    chk("R11 fault cleared", fault, 0);
    do_reset();
    wr(0, mode_word(12'h001, 12'h001, 1, 0, 0, 0, 0));
    tick(256);
    chk("R9 no fault when disabled reset", fault, 0);
    chk("R10 irq on underflow", irq, 1);
    rd(2, d); chk("R9 flag without fault", d, 1);
    chk("R11 irq cleared", irq, 0);
  endtask

  task automatic t_halts();
    logic [31:0] d;
    do_reset();
    wr(0, mode_word(12'h010, 12'h010, 0, 1, 0, 1, 1));
    cpu_idle = 1; tick(128); rd(3, d); chk("R12 idle halt", d, 32'h010);
    cpu_idle = 0; cpu_debug = 1; tick(128); rd(3, d); chk("R12 debug halt", d, 32'h010);
    cpu_debug = 0; tick(128); rd(3, d); chk("R12 runs when released", d, 32'h00F);
  endtask

  task automatic t_read_race();
    logic [31:0] d;
    do_reset();
    wr(0, mode_word(12'h100, 12'h080, 1, 1, 0, 0, 0));
    wr(1, RESTART);
    @(negedge clk);
    wr_en = 1; wr_addr = 1; wr_data = RESTART;
    rd_en = 1; rd_addr = 2;
    #1 chk("R11 read sees old error", rd_data, 2);
    @(negedge clk);
    wr_en = 0; rd_en = 0;
    chk("R11 new event wins fault", fault, 1);
    rd(2, d); chk("R11 new event wins flag", d, 2);
    rd(2, d); chk("R11 cleared after read", d, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
      end
    end
  end

  initial begin
    t_reset();
    t_prescale_key();
    t_mode_once();
    t_window();
    t_window_disabled();
    t_wide_window();
    t_underflow();
    t_halts();
    t_read_race();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule